// File: doc/BRIEF.md
# Burst Address Counter Register

This block holds the address that one memory port uses on every clock edge. It is clocked by the port clock. At each edge it does one of four things: it loads an address from outside, it steps the address it holds up by one, it keeps the address it holds, or it clears that address to zero. Three active-low strobes choose the operation. A clear request overrides a load request, and a load request overrides a step request. The operation does not depend on whether the port is selected. A deselected port can therefore clear, load or step its counter ahead of a burst.

The address that results from an edge is registered and appears on the output straight after that edge. The memory access in the same cycle uses it, so a stepped address takes effect in the cycle that produced it. Stepping up from the all-ones value wraps round to zero. The width is a parameter with a default of 15 bits. An optional register stage after the counter can delay the output for a slower memory path. This stage is off by default.

Top module: `burst_addr_ctr`

## Requirements
- R1: While rst_n is low, addr_q is 0.
- R2: If clr_n is low at a rising clock edge, addr_q is 0 after that edge, whatever ld_n and step_n are.
- R3: If clr_n is high and ld_n is low at an edge, addr_q equals ext_addr as sampled at that edge.
- R4: If clr_n and ld_n are high and step_n is low at an edge, addr_q becomes its previous value plus one.
- R5: If clr_n, ld_n and step_n are all high at an edge, addr_q keeps its previous value and ext_addr has no effect.
- R6: A step from the all-ones address gives zero.
- R7: port_sel has no effect on the result of any operation. Clear, load and step behave identically whether it is high or low.
- R8: addr_q changes only at rising clock edges or on reset. The value produced by an edge is on addr_q before the next edge, so there is no extra cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | Port selected (has no effect on the counter) |
| clr_n | input | 1 | Active-low counter clear |
| ld_n | input | 1 | Active-low address load strobe |
| step_n | input | 1 | Active-low counter advance |
| ext_addr | input | 15 | External address |
| addr_q | output | 15 | Address used for this cycle's access |

## Verification
The wrap from all ones to zero is hard to reach from the ports, because stepping there from reset would take 32768 cycles. The stimulus instead loads 0x7FFE and steps twice, so the output passes through all ones and then wraps to zero. Runs of steps are interleaved with loads, holds and clears. During those runs the unused inputs, ext_addr and port_sel, are driven with changing values, to show that they cannot disturb the priority order.

// File: rtl/burst_addr_ctr_pkg.sv
package burst_addr_ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
  import burst_addr_ctr_pkg::*;
(
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    step_n,
  output ctr_op_e op
);
  always_comb begin
    if (!clr_n)       op = OP_CLEAR;
    else if (!ld_n)   op = OP_LOAD;
    else if (!step_n) op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next_addr.sv
module bac_next_addr
  import burst_addr_ctr_pkg::*;
#(
  parameter int unsigned AW = 15
) (
  input  ctr_op_e       op,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] ext,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bac_out_stage.sv
module bac_out_stage #(
  parameter int unsigned AW    = 15,
  parameter int unsigned EXTRA = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  generate
    if (EXTRA == 0) begin : g_pass
      assign q = d;
    end else begin : g_reg
      logic [AW-1:0] stg [EXTRA];
      for (genvar i = 0; i < int'(EXTRA); i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else if (i == 0) stg[i] <= d;
          else stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
      end
      assign q = stg[EXTRA-1];
    end
  endgenerate
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_ctr_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned OUT_EXTRA = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_sel,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic          step_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_q
);
  ctr_op_e       op;
  logic [AW-1:0] cur_q, nxt;
  logic          upd_en;
  logic          unused_sel;

  assign unused_sel = port_sel;

  bac_op_decode u_dec (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .step_n(step_n),
    .op    (op)
  );

  bac_next_addr #(.AW(AW)) u_nxt (
    .op (op),
    .cur(cur_q),
    .ext(ext_addr),
    .nxt(nxt)
  );

  assign upd_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (upd_en) cur_q <= nxt;
  end

  bac_out_stage #(.AW(AW), .EXTRA(OUT_EXTRA)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cur_q),
    .q    (addr_q)
  );
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic          ld_n,
  input logic          step_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] addr_q
);
  always_comb begin
    if (!rst_n) a_rst_r1: assert (addr_q == '0);
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> addr_q == '0);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> addr_q == $past(ext_addr));
  p_step_r4_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !step_n) |=> addr_q == $past(addr_q) + 1'b1);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && step_n) |=> $stable(addr_q));
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_n   (clr_n),
  .ld_n    (ld_n),
  .step_n  (step_n),
  .ext_addr(ext_addr),
  .addr_q  (addr_q)
);

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;
  localparam int AW = 15;
  logic clk = 0, rst_n = 0, port_sel = 0, clr_n = 1, ld_n = 1, step_n = 1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_q;
  int checks = 0, fails = 0;
  logic [AW-1:0] model = '0;
  logic [AW-1:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  burst_addr_ctr u_dut (.*);

  // monitor: compares at negedge after each driven edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (addr_q !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, addr_q, e);
      end
    end
  end

  task automatic drive(input logic c, input logic l, input logic s,
                       input logic [AW-1:0] a, input logic sel, input string t);
    clr_n = c; ld_n = l; step_n = s; ext_addr = a; port_sel = sel;
    @(posedge clk);
    if (!c) model = '0;
    else if (!l) model = a;
    else if (!s) model = model + 1'b1;
    exp_q.push_back(model);
    tag_q.push_back(t);
    #1;
  endtask

  initial begin
    #2;
    checks++;
    if (addr_q !== '0) begin fails++; $display("FAIL R1: got %h expected 0", addr_q); end
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    drive(1, 0, 1, 15'h1234, 1, "R3 load");
    drive(1, 1, 0, 15'h0F0F, 1, "R4 step");
    drive(1, 1, 0, 15'h0000, 0, "R4 R7 step deselected");
    drive(1, 1, 1, 15'h7777, 1, "R5 hold ignores ext");
    drive(1, 1, 1, 15'h0001, 0, "R5 hold");
    drive(0, 0, 0, 15'h5555, 1, "R2 clear over load/step");
    drive(1, 0, 0, 15'h7FFE, 0, "R3 R7 load over step deselected");
    drive(1, 1, 0, 15'h0003, 1, "R6 step to all ones");
    drive(1, 1, 0, 15'h0003, 1, "R6 wrap to zero");
    drive(1, 1, 0, 15'h0003, 0, "R4 step after wrap");
    drive(0, 1, 1, 15'h2222, 0, "R2 R7 clear deselected");
    drive(1, 0, 1, 15'h6ABC, 1, "R3 load");
    for (int i = 0; i < 6; i++) drive(1, 1, 0, AW'(i * 97), i[0], "R4 R8 burst");
    drive(0, 1, 0, 15'h1111, 1, "R2 clear over step");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule